// File: doc/BRIEF.md
# ECC Error Status and Capture Logger

This block sits beside the ECC checker of a DRAM controller and keeps a record of memory faults for system software. The datapath reports correctable (single-bit) and uncorrectable (multi-bit) ECC events. Each report comes with the failing address, the channel it came from and the 8-bit syndrome. Three other fault sources also feed the block: a refresh timeout, a locked access that targets non-DRAM space, and a thermal trip. Each source sets a sticky flag in a 16-bit status register. Software clears a flag by writing one to it.

The address, channel and syndrome of one ECC event are held in capture registers. Correctable events never displace an earlier record. An uncorrectable event displaces a correctable record, but not an uncorrectable one. A 16-bit command register uses the same bit layout as the status register. Each command bit allows the matching flag to raise a one-cycle system-error pulse when that flag is first set.

Software reaches all registers through a flat port: a word index, a write strobe, write data, and read data that follows the index combinationally. Reads have no side effects.

Top module: `ecc_err_logger`

## Requirements
- R1: The status register is at word index 0. It holds the correctable flag at bit 0, the uncorrectable flag at bit 1, refresh timeout at bit 8, lock-to-non-DRAM at bit 9 and thermal at bit 11. All other bits, including read-data bits 31:16, read as zero.
- R2: A write to index 0 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R3: When an event and a clearing write reach the same flag in one cycle, the flag remains set. Any flag set by an event is visible on the first read after that clock edge.
- R4: The command register is at index 1. Only bits 0, 1, 8, 9 and 11 (mask 0x0B03) store written data; every other bit reads as zero.
- R5: Index 2 returns the captured address bits 31:7 in bits 31:7, zeros in bits 6:1 and the captured channel in bit 0. Address bits 6:0 are not stored, so the capture has a 128-byte grain.
- R6: Index 3 returns captured address bit 32 in bit 0, with all other bits zero. Index 4 returns the captured 8-bit syndrome in bits 7:0, with all other bits zero.
- R7: A correctable event is captured only when both the correctable and uncorrectable flags are clear before that edge. If either flag is set, the capture registers keep their previous contents.
- R8: An uncorrectable event is captured whenever the uncorrectable flag is clear before that edge, even if this overwrites a correctable record. The correctable flag stays set. When both kinds of event occur in the same cycle, the uncorrectable event is the one captured.
- R9: The system-error output is high for exactly the one cycle after an edge at which a status flag went from 0 to 1, provided that flag's command bit was set before that edge. A flag that is already set produces no pulse.
- R10: After reset, all registers read zero and the system-error output is low.
- R11: Writes to indices 2 through 7 change nothing. Reads of indices 5 through 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | Correctable ECC event strobe |
| ue_evt | input | 1 | Uncorrectable ECC event strobe |
| err_addr | input | 33 | Failing address of the ECC event |
| err_chan | input | 1 | Channel of the ECC event |
| err_syn | input | 8 | ECC syndrome of the event |
| rfto_evt | input | 1 | Refresh timeout event strobe |
| lock_evt | input | 1 | Locked access to non-DRAM event strobe |
| therm_evt | input | 1 | Thermal event strobe |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| serr_pulse | output | 1 | One-cycle system-error pulse |

## Verification
The bench builds the block with its default widths: a 33-bit address, an 8-bit syndrome, 16-bit status and command registers, and a 7-bit grain. At these widths, address bit 32 reaches the extended register, and bits 6:0 can be shown to be dropped. The random phase drives sparse events with frequent writes to all eight indices. This creates collisions between clears and events, CE/UE captures arriving in both orders, and command changes in the same cycle as an event. Every index and the pulse output are compared against a bench model each cycle.

// File: rtl/ecc_log_pkg.sv
`timescale 1ns/1ps
package ecc_log_pkg;
  localparam int STS_W     = 16;
  localparam int DATA_W    = 32;
  localparam int SYN_W     = 8;
  localparam int ADDR_W    = 33;
  localparam int GRAIN_LSB = 7;
  localparam int RIDX_W    = 3;

  localparam int B_CE    = 0;
  localparam int B_UE    = 1;
  localparam int B_RFTO  = 8;
  localparam int B_LOCK  = 9;
  localparam int B_THERM = 11;

  localparam logic [STS_W-1:0] STS_MASK = 16'h0B03;

  typedef enum logic [RIDX_W-1:0] {
    IDX_STS  = 3'd0,
    IDX_CMD  = 3'd1,
    IDX_ADR  = 3'd2,
    IDX_XADR = 3'd3,
    IDX_SYN  = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic [ADDR_W-1:GRAIN_LSB] ahi;
    logic                      chan;
    logic [SYN_W-1:0]          syn;
  } cap_rec_t;

  // sticky flags: clear where requested, then events set (event dominates)
  function automatic logic [STS_W-1:0] w1c_next(input logic [STS_W-1:0] cur,
                                                input logic [STS_W-1:0] clr,
                                                input logic [STS_W-1:0] set);
    return ((cur & ~clr) | set) & STS_MASK;
  endfunction

  function automatic logic [DATA_W-1:0] pack_adr(input cap_rec_t r);
    return {r.ahi[DATA_W-1:GRAIN_LSB], {(GRAIN_LSB-1){1'b0}}, r.chan};
  endfunction

  function automatic logic [DATA_W-1:0] pack_xadr(input cap_rec_t r);
    return {{(2*DATA_W-ADDR_W){1'b0}}, r.ahi[ADDR_W-1:DATA_W]};
  endfunction

  function automatic logic [DATA_W-1:0] pack_syn(input cap_rec_t r);
    return {{(DATA_W-SYN_W){1'b0}}, r.syn};
  endfunction
endpackage

// File: rtl/ecc_log_status.sv
`timescale 1ns/1ps
module ecc_log_status
  import ecc_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] evt_vec,
  input  logic [STS_W-1:0] clr_vec,
  input  logic [STS_W-1:0] cmd_q,
  output logic [STS_W-1:0] sts_q,
  output logic [STS_W-1:0] rise_vec,
  output logic             serr_pulse
);
  logic [STS_W-1:0] sts_nx;
  logic             serr_q;

  assign sts_nx   = w1c_next(sts_q, clr_vec, evt_vec);
  assign rise_vec = sts_nx & ~sts_q;

  for (genvar b = 0; b < STS_W; b++) begin : g_bit
    if (STS_MASK[b]) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= 1'b0;
        else        f_q <= sts_nx[b];
      end
      assign sts_q[b] = f_q;
    end else begin : g_rsvd
      assign sts_q[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_q <= 1'b0;
    else        serr_q <= |(rise_vec & cmd_q);
  end

  assign serr_pulse = serr_q;
endmodule

// File: rtl/ecc_log_cmd.sv
`timescale 1ns/1ps
module ecc_log_cmd
  import ecc_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic [STS_W-1:0] wdata,
  output logic [STS_W-1:0] cmd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (wr_cmd) cmd_q <= wdata & STS_MASK;
  end
endmodule

// File: rtl/ecc_log_capture.sv
`timescale 1ns/1ps
module ecc_log_capture
  import ecc_log_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ce_evt,
  input  logic     ue_evt,
  input  logic     ce_flag,
  input  logic     ue_flag,
  input  cap_rec_t rec_in,
  output cap_rec_t cap_q,
  output logic     cap_load
);
  logic take_ue, take_ce;

  assign take_ue  = ue_evt & ~ue_flag;
  assign take_ce  = ce_evt & ~ce_flag & ~ue_flag;
  assign cap_load = take_ue | take_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_q <= '0;
    else if (cap_load) cap_q <= rec_in;
  end
endmodule

// File: rtl/ecc_err_logger.sv
`timescale 1ns/1ps
module ecc_err_logger
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              err_chan,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              rfto_evt,
  input  logic              lock_evt,
  input  logic              therm_evt,
  input  logic [RIDX_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              serr_pulse
);
  logic [STS_W-1:0] evt_vec, clr_vec, sts_q, cmd_q, rise_vec;
  logic             wr_sts, wr_cmd, cap_load;
  cap_rec_t         rec_in, cap_q;

  assign wr_sts = reg_wr && (reg_addr == IDX_STS);
  assign wr_cmd = reg_wr && (reg_addr == IDX_CMD);
  assign clr_vec = wr_sts ? (reg_wdata[STS_W-1:0] & STS_MASK) : '0;

  always_comb begin
    evt_vec          = '0;
    evt_vec[B_CE]    = ce_evt;
    evt_vec[B_UE]    = ue_evt;
    evt_vec[B_RFTO]  = rfto_evt;
    evt_vec[B_LOCK]  = lock_evt;
    evt_vec[B_THERM] = therm_evt;
  end

  assign rec_in.ahi  = err_addr[ADDR_W-1:GRAIN_LSB];
  assign rec_in.chan = err_chan;
  assign rec_in.syn  = err_syn;

  ecc_log_status u_status (
    .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .clr_vec(clr_vec),
    .cmd_q(cmd_q), .sts_q(sts_q), .rise_vec(rise_vec), .serr_pulse(serr_pulse)
  );

  ecc_log_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd),
    .wdata(reg_wdata[STS_W-1:0]), .cmd_q(cmd_q)
  );

  ecc_log_capture u_cap (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .ce_flag(sts_q[B_CE]), .ue_flag(sts_q[B_UE]), .rec_in(rec_in),
    .cap_q(cap_q), .cap_load(cap_load)
  );

  always_comb begin
    case (reg_addr)
      IDX_STS:  reg_rdata = {{(DATA_W-STS_W){1'b0}}, sts_q};
      IDX_CMD:  reg_rdata = {{(DATA_W-STS_W){1'b0}}, cmd_q};
      IDX_ADR:  reg_rdata = pack_adr(cap_q);
      IDX_XADR: reg_rdata = pack_xadr(cap_q);
      IDX_SYN:  reg_rdata = pack_syn(cap_q);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_logger_chk.sv
`timescale 1ns/1ps
module ecc_err_logger_chk
  import ecc_log_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ce_evt,
  input logic              ue_evt,
  input logic              reg_wr,
  input logic [RIDX_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              serr_pulse,
  input logic [STS_W-1:0]  sts_q,
  input logic [STS_W-1:0]  cmd_q,
  input logic              cap_load
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~STS_MASK) == '0);

  a_r4_cmd_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q & ~STS_MASK) == '0);

  a_r2_clear_ue: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[B_UE] && !ue_evt) |=> !sts_q[B_UE]);

  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt |=> sts_q[B_CE]);

  a_r7_ce_no_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[B_CE] && !ue_evt) |-> !cap_load);

  a_r8_ue_locks: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[B_UE] |-> !cap_load);

  a_r8_ue_first_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && !sts_q[B_UE]) |-> cap_load);

  a_r9_serr_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> (sts_q & STS_MASK) != '0);
endmodule

bind ecc_err_logger ecc_err_logger_chk u_chk (.*);

// File: tb/ecc_err_logger_tb_top.sv
`timescale 1ns/1ps
module ecc_err_logger_tb_top;
  import ecc_log_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              ce_evt, ue_evt, err_chan, rfto_evt, lock_evt, therm_evt;
  logic [ADDR_W-1:0] err_addr;
  logic [SYN_W-1:0]  err_syn;
  logic [RIDX_W-1:0] reg_addr;
  logic              reg_wr;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;
  logic              serr_pulse;

  ecc_err_logger dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_sts, m_cmd;
  logic [32:7] m_ahi;
  logic        m_chan, m_serr;
  logic [7:0]  m_syn;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int idx);
    case (idx)
      0: return {16'h0, m_sts};
      1: return {16'h0, m_cmd};
      2: return {m_ahi[31:7], 6'b0, m_chan};
      3: return {31'b0, m_ahi[32]};
      4: return {24'b0, m_syn};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string idx_tag(int idx);
    case (idx)
      0: return "R1 R2 status";
      1: return "R4 command";
      2: return "R5 address";
      3: return "R6 ext address";
      4: return "R6 syndrome";
      default: return "R11 unused";
    endcase
  endfunction

  task automatic read_all(string ctx);
    for (int i = 0; i < 8; i++) begin
      reg_addr = 3'(i);
      #0.1;
      chk($sformatf("%s / %s", ctx, idx_tag(i)), reg_rdata, exp_read(i));
    end
  endtask

  task automatic idle_inputs();
    ce_evt = 0; ue_evt = 0; rfto_evt = 0; lock_evt = 0; therm_evt = 0;
    reg_wr = 0; reg_wdata = '0; reg_addr = '0;
  endtask

  // one clock with given stimulus, model update, pulse check, then readback
  task automatic cyc(string ctx, logic ce, logic ue, logic rf, logic lk, logic th,
                     logic [32:0] a, logic ch, logic [7:0] s,
                     logic wr, logic [2:0] widx, logic [31:0] wd);
    logic [15:0] setv, clrv, nx;
    @(negedge clk);
    ce_evt = ce; ue_evt = ue; rfto_evt = rf; lock_evt = lk; therm_evt = th;
    err_addr = a; err_chan = ch; err_syn = s;
    reg_wr = wr; reg_addr = widx; reg_wdata = wd;
    @(posedge clk);
    setv = 16'h0;
    setv[0] = ce; setv[1] = ue; setv[8] = rf; setv[9] = lk; setv[11] = th;
    clrv = (wr && widx == 3'd0) ? (wd[15:0] & 16'h0B03) : 16'h0;
    nx = (m_sts & ~clrv) | setv;
    m_serr = |((nx & ~m_sts) & m_cmd);
    if (ue && !m_sts[1]) begin
      m_ahi = a[32:7]; m_chan = ch; m_syn = s;
    end else if (ce && !m_sts[0] && !m_sts[1]) begin
      m_ahi = a[32:7]; m_chan = ch; m_syn = s;
    end
    if (wr && widx == 3'd1) m_cmd = wd[15:0] & 16'h0B03;
    m_sts = nx;
    #1;
    chk({ctx, " / R9 pulse"}, {31'b0, serr_pulse}, {31'b0, m_serr});
    @(negedge clk);
    idle_inputs();
    read_all(ctx);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    idle_inputs();
    err_addr = '0; err_chan = 0; err_syn = '0;
    m_sts = 0; m_cmd = 0; m_ahi = 0; m_chan = 0; m_syn = 0; m_serr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset pulse", {31'b0, serr_pulse}, 32'h0);
    read_all("R10 reset");
    rst_n = 1;

    // command: write all ones, only mask bits stick
    cyc("R4 cmd all ones", 0,0,0,0,0, 33'h0, 0, 8'h0, 1, 3'd1, 32'hFFFF_FFFF);
    // first CE captured, pulse fires; low address bits dropped
    cyc("R7 first CE", 1,0,0,0,0, 33'h1_2345_67FF, 1, 8'h5A, 0, 3'd0, 0);
    chk("R5 grain", exp_read(2), 32'h2345_6781);
    chk("R6 ext bit", exp_read(3), 32'h1);
    // second CE keeps the record and gives no pulse
    cyc("R7 CE while CE set", 1,0,0,0,0, 33'h0_0BAD_0000, 0, 8'h11, 0, 3'd0, 0);
    // UE overwrites CE record, CE flag kept
    cyc("R8 UE over CE", 0,1,0,0,0, 33'h0_8000_0080, 0, 8'hC3, 0, 3'd0, 0);
    chk("R8 both flags", exp_read(0), 32'h0000_0003);
    cyc("R8 CE after UE", 1,0,0,0,0, 33'h1_FFFF_FFFF, 1, 8'hEE, 0, 3'd0, 0);
    cyc("R8 UE after UE", 0,1,0,0,0, 33'h1_0000_1000, 1, 8'h77, 0, 3'd0, 0);
    // clear all while CE event in same cycle: CE stays, UE goes
    cyc("R3 clear vs event", 1,0,0,0,0, 33'h0_0000_4000, 1, 8'h22, 1, 3'd0, 32'h0000_0B03);
    chk("R3 CE kept", exp_read(0), 32'h0000_0001);
    // writing zeros leaves flags
    cyc("R2 write zero", 0,0,0,0,0, 33'h0, 0, 8'h0, 1, 3'd0, 32'h0);
    cyc("R2 clear CE", 0,0,0,0,0, 33'h0, 0, 8'h0, 1, 3'd0, 32'h0000_0001);
    // other sources set their bits
    cyc("R1 rfto lock therm", 0,0,1,1,1, 33'h0, 0, 8'h0, 0, 3'd0, 0);
    chk("R1 layout", exp_read(0), 32'h0000_0B00);
    // disabled command: no pulse
    cyc("R9 cmd off", 0,0,0,0,0, 33'h0, 0, 8'h0, 1, 3'd1, 32'h0);
    cyc("R9 clear all", 0,0,0,0,0, 33'h0, 0, 8'h0, 1, 3'd0, 32'hFFFF);
    cyc("R9 thermal masked", 0,0,0,0,1, 33'h0, 0, 8'h0, 0, 3'd0, 0);
    // command written in same cycle as event: old value governs
    cyc("R9 cmd same cycle", 0,0,0,1,0, 33'h0, 0, 8'h0, 1, 3'd1, 32'h0200);
    // writes to read-only and unused indices
    cyc("R11 write adr", 0,0,0,0,0, 33'h0, 0, 8'h0, 1, 3'd2, 32'hFFFF_FFFF);
    cyc("R11 write xadr", 0,0,0,0,0, 33'h0, 0, 8'h0, 1, 3'd3, 32'hFFFF_FFFF);
    cyc("R11 write syn", 0,0,0,0,0, 33'h0, 0, 8'h0, 1, 3'd4, 32'hFFFF_FFFF);
    cyc("R11 write idx6", 0,0,0,0,0, 33'h0, 0, 8'h0, 1, 3'd6, 32'hFFFF_FFFF);
    // simultaneous CE and UE from clean flags
    cyc("R8 clear for pair", 0,0,0,0,0, 33'h0, 0, 8'h0, 1, 3'd0, 32'hFFFF);
    cyc("R8 CE+UE together", 1,1,0,0,0, 33'h1_3579_BDF0, 1, 8'h9C, 0, 3'd0, 0);

    // constrained random phase
    for (int n = 0; n < 400; n++) begin
      logic wr;
      logic [2:0] widx;
      logic [31:0] wd;
      wr   = ($urandom % 4) == 0;
      widx = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'($urandom % 2);
      wd   = $urandom;
      cyc("random", ($urandom % 8) == 0, ($urandom % 16) == 0,
          ($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 16) == 0,
          {1'($urandom), 32'($urandom)}, 1'($urandom), 8'($urandom),
          wr, widx, wd);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule